// File: doc/BRIEF.md
# Cluster-Addressed Fast IPI Request Unit

This block lets every CPU of a clustered system raise an inter-processor interrupt on any other CPU. Each CPU owns two request ports. The local port reaches only CPUs inside the requester's own cluster. The global port names both a cluster and a CPU. A request word selects one of four delivery kinds. An immediate request raises the target's pending flag at once. A deferred request raises it after a programmable delay. A retract request cancels a deferred request that has not yet fired. A no-wake request raises the flag without the wake pulse.

Every CPU has its own pending flag, and that flag drives the CPU's fast-interrupt line directly. A CPU clears its flag by writing a 1 to bit 0 of its status port. Each CPU also holds a countdown register. When that CPU issues a deferred request, the register supplies the delay. A one-cycle wake pulse goes with every pending set made by an immediate request or a deferred one. The default build has 2 clusters of 4 CPUs, which gives 8 CPUs numbered cluster * 4 + cpu.

Top module: `ipi_fast_req_unit`

## Requirements
- R1: Request word fields are: target CPU index in bits 7:0, cluster index in bits 23:16, and kind in bits 29:28. A local-port request always targets the requester's own cluster (requester index divided by CPUs per cluster), whatever bits 23:16 hold.
- R2: A global-port request targets CPU number cluster * CPUS_PER_CLUSTER + cpu, taken from bits 23:16 and 7:0.
- R3: Kind 0 (immediate) sets the target's pending flag at the clock edge that samples the request. The same edge raises the target's wake output for exactly one cycle.
- R4: fiq_o of a CPU equals its pending flag. The flag stays set until that CPU clears it.
- R5: A status write with bit 0 = 1 clears the writer's pending flag. A write with bit 0 = 0 has no effect. A set arriving in the same cycle as a clear wins.
- R6: Kind 2 (deferred) loads the target's timer with the requester's countdown value D. Pending and a wake pulse appear D+1 clock edges after the request edge.
- R7: Kind 1 (retract) cancels a deferred request that is still counting for its target. It never clears a flag that is already pending. When a retract and a deferred request reach the same target in the same cycle, the retract wins.
- R8: Kind 3 (no-wake) sets the target's pending flag without any wake pulse.
- R9: A request whose CPU index is not below CPUS_PER_CLUSTER is ignored. A global request whose cluster index is not below NUM_CLUSTERS is also ignored.
- R10: Reset clears every pending flag, wake output and timer, and sets every countdown register to 0.
- R11: A deferred request to a target whose timer is still counting restarts that timer with the new delay. When several deferred requests reach one target in the same cycle, the lowest source wins: local ports 0..N-1 rank ahead of global ports 0..N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_req_vld | input | N_CPU | Local request strobe, one per requesting CPU |
| loc_req_word | input | 32*N_CPU | Local request words, CPU i at bits 32i+31:32i |
| glb_req_vld | input | N_CPU | Global request strobe, one per requesting CPU |
| glb_req_word | input | 32*N_CPU | Global request words, CPU i at bits 32i+31:32i |
| stat_wr_vld | input | N_CPU | Status-write strobe per CPU |
| stat_wr_word | input | 32*N_CPU | Status-write data; bit 0 = 1 clears pending |
| cdn_wr_vld | input | N_CPU | Countdown-register write strobe per CPU |
| cdn_wr_val | input | CNT_W*N_CPU | New countdown values |
| fiq_o | output | N_CPU | Fast-interrupt line per CPU (pending flag) |
| wake_o | output | N_CPU | One-cycle wake pulse per CPU |

## Verification
The bound checker watches every CPU on every cycle and enforces several invariants. Wake is never high without pending. A pending flag falls only after a status write with bit 0 = 1 to that CPU. A flag rises only after a request or while its timer is armed. A timer disarms only when its flag fires or after a request. All outputs are quiet just after reset. The exact target decode, the out-of-range drops, the D+1 delay, the retract cancellation and the arbitration among same-cycle requests depend on the request contents. Only the bench's sweeps show those behaviours. They cover every requester, port, cluster field and CPU field, including values one past the valid range.

// File: rtl/ipi_req_pkg.sv
package ipi_req_pkg;

    // Bit positions of the request word (software decodes these)
    localparam int CPU_LSB  = 0;
    localparam int CL_LSB   = 16;
    localparam int KIND_LSB = 28;
    localparam int WORD_W   = 32;

    typedef enum logic [1:0] {
        KIND_NOW     = 2'd0,
        KIND_CANCEL  = 2'd1,
        KIND_LATER   = 2'd2,
        KIND_SILENT  = 2'd3
    } req_kind_e;

endpackage

// File: rtl/ipi_req_decode.sv
module ipi_req_decode
    import ipi_req_pkg::*;
#(
    parameter int NUM_CLUSTERS     = 2,
    parameter int CPUS_PER_CLUSTER = 4,
    parameter bit IS_GLOBAL        = 1'b0,
    parameter int OWN_CLUSTER      = 0
) (
    input  logic                                       vld_i,
    input  logic [WORD_W-1:0]                          word_i,
    output logic [NUM_CLUSTERS*CPUS_PER_CLUSTER-1:0]   hit_o,
    output req_kind_e                                  kind_o
);
    localparam int N_CPU = NUM_CLUSTERS * CPUS_PER_CLUSTER;
    localparam logic [7:0] CPC8 = 8'(CPUS_PER_CLUSTER);
    localparam logic [7:0] NCL8 = 8'(NUM_CLUSTERS);
    localparam logic [7:0] OWN8 = 8'(OWN_CLUSTER);

    logic [7:0]  cpu_f;
    logic [7:0]  cl_f;
    logic        in_range;
    logic [15:0] tgt;
    logic        unused_bits;

    always_comb begin
        cpu_f    = word_i[CPU_LSB +: 8];
        cl_f     = IS_GLOBAL ? word_i[CL_LSB +: 8] : OWN8;
        in_range = (cpu_f < CPC8) && (cl_f < NCL8);
        tgt      = 16'(cl_f) * 16'(CPUS_PER_CLUSTER) + 16'(cpu_f);
        kind_o   = req_kind_e'(word_i[KIND_LSB +: 2]);
    end

    assign unused_bits = ^{word_i[31:30], word_i[27:24], word_i[23:16], word_i[15:8]};

    for (genvar t = 0; t < N_CPU; t++) begin : g_hit
        assign hit_o[t] = vld_i && in_range && (tgt == 16'(t));
    end

endmodule

// File: rtl/ipi_target_slot.sv
module ipi_target_slot #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             now_i,
    input  logic             silent_i,
    input  logic             later_i,
    input  logic             cancel_i,
    input  logic [CNT_W-1:0] later_val_i,
    output logic             pend_o,
    output logic             wake_o,
    output logic             armed_o
);
    typedef struct packed {
        logic             pend;
        logic             wake;
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t slot_q, slot_d;
    logic  fire;

    always_comb begin
        slot_d      = slot_q;
        slot_d.wake = 1'b0;
        fire        = slot_q.armed && (slot_q.cnt == '0);
        if (slot_q.armed) begin
            if (fire) slot_d.armed = 1'b0;
            else      slot_d.cnt   = slot_q.cnt - 1'b1;
        end
        if (clr_i) slot_d.pend = 1'b0;
        if (later_i) begin
            slot_d.armed = 1'b1;
            slot_d.cnt   = later_val_i;
        end
        if (cancel_i) slot_d.armed = 1'b0;
        if (now_i || fire) begin
            slot_d.pend = 1'b1;
            slot_d.wake = 1'b1;
        end
        if (silent_i) slot_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign pend_o  = slot_q.pend;
    assign wake_o  = slot_q.wake;
    assign armed_o = slot_q.armed;

endmodule

// File: rtl/ipi_fast_req_unit.sv
module ipi_fast_req_unit
    import ipi_req_pkg::*;
#(
    parameter int NUM_CLUSTERS     = 2,
    parameter int CPUS_PER_CLUSTER = 4,
    parameter int CNT_W            = 16,
    localparam int N_CPU           = NUM_CLUSTERS * CPUS_PER_CLUSTER
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CPU-1:0]          loc_req_vld,
    input  logic [WORD_W*N_CPU-1:0]   loc_req_word,
    input  logic [N_CPU-1:0]          glb_req_vld,
    input  logic [WORD_W*N_CPU-1:0]   glb_req_word,
    input  logic [N_CPU-1:0]          stat_wr_vld,
    input  logic [WORD_W*N_CPU-1:0]   stat_wr_word,
    input  logic [N_CPU-1:0]          cdn_wr_vld,
    input  logic [CNT_W*N_CPU-1:0]    cdn_wr_val,
    output logic [N_CPU-1:0]          fiq_o,
    output logic [N_CPU-1:0]          wake_o
);
    localparam int N_SRC = 2 * N_CPU;

    // Countdown register bank, two-process
    typedef struct packed {
        logic [N_CPU-1:0][CNT_W-1:0] val;
    } cdn_t;

    cdn_t cdn_q, cdn_d;

    always_comb begin
        cdn_d = cdn_q;
        for (int i = 0; i < N_CPU; i++) begin
            if (cdn_wr_vld[i]) cdn_d.val[i] = cdn_wr_val[i*CNT_W +: CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cdn_q <= '0;
        else        cdn_q <= cdn_d;
    end

    // Request decode: sources 0..N-1 are local ports, N..2N-1 global ports
    logic      [N_SRC-1:0][N_CPU-1:0] src_hit;
    req_kind_e [N_SRC-1:0]            src_kind;

    for (genvar s = 0; s < N_CPU; s++) begin : g_dec
        ipi_req_decode #(
            .NUM_CLUSTERS    (NUM_CLUSTERS),
            .CPUS_PER_CLUSTER(CPUS_PER_CLUSTER),
            .IS_GLOBAL       (1'b0),
            .OWN_CLUSTER     (s / CPUS_PER_CLUSTER)
        ) loc_dec_i (
            .vld_i (loc_req_vld[s]),
            .word_i(loc_req_word[s*WORD_W +: WORD_W]),
            .hit_o (src_hit[s]),
            .kind_o(src_kind[s])
        );
        ipi_req_decode #(
            .NUM_CLUSTERS    (NUM_CLUSTERS),
            .CPUS_PER_CLUSTER(CPUS_PER_CLUSTER),
            .IS_GLOBAL       (1'b1),
            .OWN_CLUSTER     (0)
        ) glb_dec_i (
            .vld_i (glb_req_vld[s]),
            .word_i(glb_req_word[s*WORD_W +: WORD_W]),
            .hit_o (src_hit[N_CPU + s]),
            .kind_o(src_kind[N_CPU + s])
        );
    end

    // Per-target merge of all sources
    logic [N_CPU-1:0]            t_now, t_silent, t_later, t_cancel, t_clr;
    logic [N_CPU-1:0][CNT_W-1:0] t_later_val;
    logic [N_CPU-1:0]            armed_w;
    logic                        unused_stat;

    always_comb begin
        t_now       = '0;
        t_silent    = '0;
        t_later     = '0;
        t_cancel    = '0;
        t_later_val = '0;
        for (int t = 0; t < N_CPU; t++) begin
            t_clr[t] = stat_wr_vld[t] && stat_wr_word[t*WORD_W];
            for (int s = 0; s < N_SRC; s++) begin
                if (src_hit[s][t]) begin
                    unique case (src_kind[s])
                        KIND_NOW:    t_now[t]    = 1'b1;
                        KIND_SILENT: t_silent[t] = 1'b1;
                        KIND_CANCEL: t_cancel[t] = 1'b1;
                        KIND_LATER: begin
                            if (!t_later[t]) t_later_val[t] = cdn_q.val[s % N_CPU];
                            t_later[t] = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign unused_stat = ^stat_wr_word;

    for (genvar t = 0; t < N_CPU; t++) begin : g_slot
        ipi_target_slot #(.CNT_W(CNT_W)) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_i      (t_clr[t]),
            .now_i      (t_now[t]),
            .silent_i   (t_silent[t]),
            .later_i    (t_later[t]),
            .cancel_i   (t_cancel[t]),
            .later_val_i(t_later_val[t]),
            .pend_o     (fiq_o[t]),
            .wake_o     (wake_o[t]),
            .armed_o    (armed_w[t])
        );
    end

endmodule

// File: rtl/ipi_fast_req_unit_chk.sv
module ipi_fast_req_unit_chk #(
    parameter int N_CPU = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_CPU-1:0]      loc_req_vld,
    input logic [N_CPU-1:0]      glb_req_vld,
    input logic [N_CPU-1:0]      stat_wr_vld,
    input logic [32*N_CPU-1:0]   stat_wr_word,
    input logic [N_CPU-1:0]      fiq_o,
    input logic [N_CPU-1:0]      wake_o,
    input logic [N_CPU-1:0]      armed_w
);
    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (fiq_o == '0 && wake_o == '0));

    for (genvar t = 0; t < N_CPU; t++) begin : g_t
        // R3 / R8: a wake pulse only accompanies a pending flag
        a_r3_wake_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
            wake_o[t] |-> fiq_o[t]);

        a_r5_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fiq_o[t]) |-> $past(stat_wr_vld[t] && stat_wr_word[t*32]));

        a_r4_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fiq_o[t]) |-> $past((|loc_req_vld) || (|glb_req_vld) || armed_w[t]));

        a_r7_disarm_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(armed_w[t]) |-> (fiq_o[t] || $past((|loc_req_vld) || (|glb_req_vld))));
    end

endmodule

bind ipi_fast_req_unit ipi_fast_req_unit_chk #(.N_CPU(N_CPU)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .loc_req_vld (loc_req_vld),
    .glb_req_vld (glb_req_vld),
    .stat_wr_vld (stat_wr_vld),
    .stat_wr_word(stat_wr_word),
    .fiq_o       (fiq_o),
    .wake_o      (wake_o),
    .armed_w     (armed_w)
);

// File: tb/ipi_fast_req_unit_tb_top.sv
module ipi_fast_req_unit_tb_top;
    localparam int NCL   = 2;
    localparam int CPC   = 4;
    localparam int N     = NCL * CPC;
    localparam int CNT_W = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N-1:0]       loc_vld = '0, glb_vld = '0, st_vld = '0, cd_vld = '0;
    logic [32*N-1:0]    loc_word = '0, glb_word = '0, st_word = '0;
    logic [CNT_W*N-1:0] cd_val = '0;
    logic [N-1:0]       fiq, wake;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;  // 250 MHz

    ipi_fast_req_unit #(.NUM_CLUSTERS(NCL), .CPUS_PER_CLUSTER(CPC), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .loc_req_vld(loc_vld), .loc_req_word(loc_word),
        .glb_req_vld(glb_vld), .glb_req_word(glb_word),
        .stat_wr_vld(st_vld), .stat_wr_word(st_word),
        .cdn_wr_vld(cd_vld), .cdn_wr_val(cd_val),
        .fiq_o(fiq), .wake_o(wake)
    );

    function automatic logic [31:0] mk(int kind, int cl, int cpu);
        return {2'b00, 2'(kind), 4'h0, 8'(cl), 8'h00, 8'(cpu)};
    endfunction

    function automatic logic [N-1:0] one(int t);
        return N'(1) << t;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(bit glb, int r, logic [31:0] w);
        @(negedge clk);
        if (glb) begin glb_vld[r] = 1'b1; glb_word[r*32 +: 32] = w; end
        else     begin loc_vld[r] = 1'b1; loc_word[r*32 +: 32] = w; end
        @(negedge clk);
        glb_vld = '0;
        loc_vld = '0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        st_vld  = '1;
        st_word = {N{32'h0000_0001}};
        @(negedge clk);
        st_vld  = '0;
    endtask

    task automatic set_cdn(int r, int v);
        @(negedge clk);
        cd_vld[r] = 1'b1;
        cd_val[r*CNT_W +: CNT_W] = CNT_W'(v);
        @(negedge clk);
        cd_vld = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        // R10: reset state
        idle(3);
        chk("R10 fiq in reset", 32'(fiq), 32'h0);
        chk("R10 wake in reset", 32'(wake), 32'h0);
        rst_n = 1'b1;
        idle(2);
        chk("R10 fiq after reset", 32'(fiq), 32'h0);

        // R10: countdown resets to 0 -> deferred fires one edge later
        send(1'b1, 0, mk(2, 0, 3));
        chk("R10 zero countdown E0", 32'(fiq), 32'h0);
        @(negedge clk);
        chk("R10 zero countdown E1", 32'(fiq), 32'(one(3)));
        clear_all();

        // R1 R2 R3 R4 R9: sweep of ports, requesters, cluster and cpu fields
        for (int g = 0; g < 2; g++) begin
            for (int r = 0; r < N; r++) begin
                for (int cl = 0; cl <= NCL; cl++) begin
                    for (int cpu = 0; cpu <= CPC; cpu++) begin
                        logic [N-1:0] exp;
                        string tag;
                        int ecl;
                        ecl = (g == 1) ? cl : r / CPC;
                        if (cpu >= CPC || ecl >= NCL) begin
                            exp = '0; tag = "R9";
                        end else begin
                            exp = one(ecl * CPC + cpu);
                            tag = (g == 1) ? "R2" : "R1";
                        end
                        send(g[0], r, mk(0, cl, cpu));
                        chk({tag, " target"}, 32'(fiq), 32'(exp));
                        chk("R3 wake pulse", 32'(wake), 32'(exp));
                        @(negedge clk);
                        chk("R3 wake one cycle", 32'(wake), 32'h0);
                        chk("R4 pending held", 32'(fiq), 32'(exp));
                        clear_all();
                        chk("R5 cleared", 32'(fiq), 32'h0);
                    end
                end
            end
        end

        // R5: bit0 = 0 write ignored, bit0 = 1 clears, set beats clear
        send(1'b0, 0, mk(0, 0, 3));
        @(negedge clk);
        st_vld[3] = 1'b1; st_word[3*32 +: 32] = 32'hFFFF_FFFE;
        @(negedge clk);
        st_vld = '0;
        chk("R5 bit0=0 ignored", 32'(fiq), 32'(one(3)));
        @(negedge clk);
        st_vld[3] = 1'b1; st_word[3*32 +: 32] = 32'h1;
        loc_vld[1] = 1'b1; loc_word[1*32 +: 32] = mk(0, 0, 3);
        @(negedge clk);
        st_vld = '0; loc_vld = '0;
        chk("R5 set wins over clear", 32'(fiq), 32'(one(3)));
        @(negedge clk);
        st_vld[3] = 1'b1; st_word[3*32 +: 32] = 32'h1;
        @(negedge clk);
        st_vld = '0;
        chk("R5 bit0=1 clears", 32'(fiq), 32'h0);

        // R6: deferred delay sweep
        for (int d = 0; d < 7; d++) begin
            for (int k = 0; k < 2; k++) begin
                int r, t;
                r = (k == 0) ? 1 : 6;
                t = (d + r) % N;
                set_cdn(r, d);
                send(1'b1, r, mk(2, t / CPC, t % CPC));
                for (int e = 0; e <= d; e++) begin
                    chk("R6 not yet pending", 32'(fiq), 32'h0);
                    @(negedge clk);
                end
                chk("R6 pending at D+1", 32'(fiq), 32'(one(t)));
                chk("R6 wake at fire", 32'(wake), 32'(one(t)));
                clear_all();
            end
        end

        // R7: retract cancels a counting deferred request
        set_cdn(2, 10);
        send(1'b1, 2, mk(2, 1, 1));
        idle(3);
        send(1'b0, 7, mk(1, 0, 1));
        idle(15);
        chk("R7 retract cancels", 32'(fiq), 32'h0);
        chk("R7 no wake after retract", 32'(wake), 32'h0);
        // R7: retract leaves pending flag alone
        send(1'b1, 0, mk(0, 1, 1));
        send(1'b1, 0, mk(1, 1, 1));
        @(negedge clk);
        chk("R7 retract keeps pending", 32'(fiq), 32'(one(5)));
        clear_all();
        // R7: same-cycle retract beats deferred
        set_cdn(4, 2);
        @(negedge clk);
        loc_vld[4] = 1'b1; loc_word[4*32 +: 32] = mk(2, 0, 1);
        loc_vld[5] = 1'b1; loc_word[5*32 +: 32] = mk(1, 0, 1);
        @(negedge clk);
        loc_vld = '0;
        idle(8);
        chk("R7 retract wins same cycle", 32'(fiq), 32'h0);

        // R8: no-wake sets pending silently
        send(1'b1, 0, mk(3, 1, 2));
        chk("R8 pending set", 32'(fiq), 32'(one(6)));
        chk("R8 no wake", 32'(wake), 32'h0);
        @(negedge clk);
        chk("R8 still no wake", 32'(wake), 32'h0);
        clear_all();

        // R11: same-cycle deferred arbitration, local port 1 beats global port 5
        set_cdn(1, 3);
        set_cdn(5, 9);
        @(negedge clk);
        loc_vld[1] = 1'b1; loc_word[1*32 +: 32] = mk(2, 1, 0);
        glb_vld[5] = 1'b1; glb_word[5*32 +: 32] = mk(2, 0, 0);
        @(negedge clk);
        loc_vld = '0; glb_vld = '0;
        for (int e = 0; e < 3; e++) begin
            chk("R11 priority not yet", 32'(fiq), 32'h0);
            @(negedge clk);
        end
        chk("R11 priority still early", 32'(fiq), 32'h0);
        @(negedge clk);
        chk("R11 lowest source delay", 32'(fiq), 32'(one(0)));
        clear_all();
        idle(10);
        // R11: restart with new value
        set_cdn(0, 8);
        set_cdn(1, 2);
        send(1'b0, 0, mk(2, 0, 2));
        send(1'b0, 1, mk(2, 0, 2));
        for (int e = 0; e < 3; e++) begin
            chk("R11 restart not yet", 32'(fiq), 32'h0);
            @(negedge clk);
        end
        chk("R11 restart fires", 32'(fiq), 32'(one(2)));
        clear_all();
        idle(10);
        chk("R11 old timer discarded", 32'(fiq), 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule